// File: doc/BRIEF.md
# Time-Sliced Round-Robin Arbiter

This block shares one resource among four requesters. A requester keeps its grant for a fixed time slice, which a small cycle counter measures. When the slice runs out, the grant moves to the next requesting line in circular order. No line has a fixed priority, so every line that keeps requesting is served within one full rotation.

If the current holder lowers its request before its slice is over, the arbiter gives the grant to the next requester at once, so the rest of the slice is not wasted. Lines that are not requesting are skipped. When nothing is requested, no grant is driven.

The grant is a registered one-hot vector. A requester sees its grant on the clock edge after the condition that triggered the handover.

Top module: `rr_slice_arbiter`

## Requirements
- R1: The grant vector `gnt` is one-hot or all zero, and only a line whose `req` bit was high in the previous cycle can hold a grant.
- R2: While `rst_n` is low, `gnt` is zero. After reset the search pointer is at line 0, so with every line requesting, line 0 is granted first.
- R3: The grant is registered. A line that requests while nothing is granted receives its grant on the next rising clock edge.
- R4: A holder that keeps its request high keeps its grant for exactly SLICE = 2^CNT_W cycles (4 with the default `CNT_W` of 2).
- R5: When a slice expires, the search for the next owner starts at the line after the holder and wraps from line 3 to line 0. The first requesting line found wins.
- R6: When a slice expires and no other line requests while the holder still does, the holder is granted again for a fresh full slice.
- R7: If the holder's `req` is low in a cycle, then on the next edge the grant passes to the next requesting line in circular order after the holder. If no line requests, the grant becomes zero.
- R8: When no line requests, `gnt` is zero from the next edge onward. The next grant after such an idle period goes to the first requesting line at or after the line following the last grant holder.
- R9: The slice counter restarts at every new grant, so each new owner gets a full slice. This holds even when the previous slice was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request lines, bit i for requester i |
| gnt | output | 4 | Registered one-hot grant, bit i for requester i |

## Verification
The bench goes after four cases:
- The wrap from line 3 back to line 0. A pointer that failed to wrap would starve line 0 or grant a line that is not requesting.
- A sole requester at slice expiry. A design that did not re-grant it would drop the grant for a cycle, and one that did not restart the counter would cut its next slice short.
- Early release in every counter phase. A design that ignored the dropped request would hold a dead grant for the rest of the slice.
- An idle period followed by new requests. A design that searched from line 0 instead of the stored pointer would break the circular order.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // What the arbiter did on the last clock edge; exposed for checking.
  typedef enum logic [2:0] {
    ARB_EV_NONE    = 3'd0,
    ARB_EV_HOLD    = 3'd1,
    ARB_EV_EXPIRE  = 3'd2,
    ARB_EV_RELEASE = 3'd3,
    ARB_EV_START   = 3'd4
  } arb_ev_e;

  // Circular successor of an index among n lines.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Index reached by stepping off places from start among n lines.
  function automatic int unsigned wrap_add(int unsigned start, int unsigned off,
                                           int unsigned n);
    return (start + off) % n;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_LINES = 4,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] req,
  input  logic [IDX_W-1:0]   start,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  import rr_arb_pkg::*;

  // Scan from the farthest offset to the nearest; the nearest hit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      int unsigned cand;
      cand = wrap_add(int'(start), k, N_LINES);
      if (req[cand]) begin
        found = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             at_end
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (restart) begin
      count_q <= '0;
    end else if (advance) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count  = count_q;
  assign at_end = (count_q == LAST);

endmodule

// File: rtl/rr_slice_arbiter.sv
module rr_slice_arbiter #(
  parameter int N_LINES = 4,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req,
  output logic [N_LINES-1:0] gnt
);
  import rr_arb_pkg::*;

  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  // Owner state
  logic             own_v_q;
  logic [IDX_W-1:0] own_q;
  logic [IDX_W-1:0] ptr_q;

  // Named internal events
  logic             holder_req;
  logic             slice_done;
  logic             early_rel;
  logic             need_pick;
  logic             handover;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [CNT_W-1:0] slice_cnt;
  logic             slice_end;
  arb_ev_e          ev_d;
  arb_ev_e          ev_q;

  assign holder_req = own_v_q & req[own_q];
  assign slice_done = holder_req & slice_end;
  assign early_rel  = own_v_q & ~req[own_q];
  assign need_pick  = ~own_v_q | slice_done | early_rel;
  assign handover   = need_pick & pick_found;

  // The pointer always sits one past the latest winner, so the same
  // search serves expiry, early release and the start after idle.
  rr_pick #(.N_LINES(N_LINES)) u_pick (
    .req   (req),
    .start (ptr_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  slice_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (handover),
    .advance (holder_req),
    .count   (slice_cnt),
    .at_end  (slice_end)
  );

  always_comb begin
    if (!own_v_q)        ev_d = pick_found ? ARB_EV_START : ARB_EV_NONE;
    else if (early_rel)  ev_d = ARB_EV_RELEASE;
    else if (slice_done) ev_d = ARB_EV_EXPIRE;
    else                 ev_d = ARB_EV_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v_q <= 1'b0;
      own_q   <= '0;
      ptr_q   <= '0;
      ev_q    <= ARB_EV_NONE;
    end else begin
      ev_q <= ev_d;
      if (need_pick) begin
        own_v_q <= pick_found;
        if (pick_found) begin
          own_q <= pick_idx;
          ptr_q <= IDX_W'(wrap_next(int'(pick_idx), N_LINES));
        end
      end
    end
  end

  // One decoder bit per line
  for (genvar g = 0; g < N_LINES; g++) begin : g_gnt
    assign gnt[g] = own_v_q && (own_q == IDX_W'(g));
  end

  // slice_cnt and ev_q stay visible for inspection only.
  logic unused_ok;
  assign unused_ok = ^{slice_cnt, ev_q};

endmodule

// File: rtl/rr_slice_arbiter_chk.sv
module rr_slice_arbiter_chk #(
  parameter int N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] req,
  input logic [N_LINES-1:0] gnt,
  input logic               slice_done,
  input logic               early_rel
);

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & $past(req))));

  assert_hold_within_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & req)) && !slice_done) |=> $stable(gnt));

  assert_rotate_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_done && (|(req & ~gnt))) |=> (gnt != $past(gnt)));

  assert_early_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (early_rel && (|(gnt & ~req))) |=> ((gnt & $past(gnt)) == '0));

  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt == '0));

endmodule

bind rr_slice_arbiter rr_slice_arbiter_chk #(.N_LINES(N_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .gnt        (gnt),
  .slice_done (slice_done),
  .early_rel  (early_rel)
);

// File: tb/test_rr_slice_arbiter.sv
module test_rr_slice_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int SLICE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req = '0;
  logic [NL-1:0] gnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  int    m_owner = -1;   // -1: nothing granted
  int    m_used  = 0;    // cycles of the current slice already served
  int    m_ptr   = 0;
  string m_tag   = "R2";

  rr_slice_arbiter i_rr_slice_arbiter (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int first_from(logic [NL-1:0] r, int start);
    for (int k = 0; k < NL; k++) begin
      if (r[(start + k) % NL]) return (start + k) % NL;
    end
    return -1;
  endfunction

  function automatic logic [NL-1:0] model_gnt();
    return (m_owner < 0) ? '0 : (NL'(1) << m_owner);
  endfunction

  // Behavioural model: a fresh search whenever the holder is gone,
  // has let go, or has used up its slice.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = -1; m_used = 0; m_ptr = 0; m_tag = "R2";
    end else begin
      int  w;
      bit  search;
      search = 0;
      if (m_owner < 0) begin
        search = 1; m_tag = "R3/R8";
      end else if (!req[m_owner]) begin
        search = 1; m_tag = "R7";
      end else if (m_used + 1 >= SLICE) begin
        search = 1; m_tag = "R5/R6";
      end else begin
        m_used++; m_tag = "R4";
      end
      if (search) begin
        w = first_from(req, m_ptr);
        if (w >= 0) begin
          if (m_tag == "R3/R8" || m_tag == "R7") m_tag = {m_tag, "/R9"};
          m_owner = w; m_used = 0; m_ptr = (w + 1) % NL;
        end else begin
          m_owner = -1;
        end
      end
    end
  end

  task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) check(m_tag, gnt, model_gnt());
  end

  task automatic drive(logic [NL-1:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = v;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", gnt, '0);
    rst_n = 1'b1;
    // R2/R3/R4/R5: all request, rotation 0,1,2,3 and wrap to 0
    drive(4'hF, 1);
    @(negedge clk);
    check("R2 first grant line0", gnt, 4'b0001);
    drive(4'hF, 4 * SLICE + 2);
    // R6: sole requester re-granted
    drive(4'b0100, 3 * SLICE);
    // R7/R9: early release at various phases
    drive(4'b1011, 2);
    drive(4'b1010, 1);
    drive(4'b1010, 1);
    drive(4'b0010, 2);
    drive(4'b0000, 1);
    // R8: idle then resume from pointer
    drive(4'b0000, 3);
    drive(4'b1001, 6);
    drive(4'b0000, 2);
    drive(4'b0011, 6);
    // Random traffic with frequent drops
    for (int i = 0; i < 600; i++) begin
      drive(NL'($urandom_range(0, 15)), $urandom_range(1, 6));
    end
    // Reset in the middle of a grant
    drive(4'hF, 2);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 mid-run reset", gnt, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 restart at line0", gnt, 4'b0001);
    drive(4'hF, 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule